// File: doc/BRIEF.md
# Ping-Pong Byte Stream DMA Engine

This block moves bytes, one at a time, between system memory and a byte-wide peripheral such as a printer port. Software describes a buffer in a 64-bit context word. There are two such words, A and B, and the engine works through them in turn. While one buffer drains, software refills the other, so the stream runs without a gap. A small register bus gives access to both context words, a control word and a read-only diagnostic word.

On the memory side there is a request/grant port that carries one byte per access. On the device side there is a valid/ready byte stream for each direction. A terminal-count pulse tells the device that a buffer marked as last has been fully moved. Each context has its own completion interrupt, and a third interrupt reports a badly placed buffer.

Register addresses are: 0 for context A, 1 for context B, 2 for control and 3 for diagnostic. Reads return data in the same cycle.

Top module: `pingpong_dma`

## Requirements
- R1: The context word holds the buffer base address in bits 31:0, the byte count in bits 43:32 and the last-buffer flag in bit 63. The engine moves exactly that many bytes at ascending addresses from the base. A count of zero completes with no traffic.
- R2: Control bit 0 sets the direction. A value of 0 reads memory and sends the bytes in order on the device output stream. A value of 1 takes bytes from the device input stream and writes them to memory.
- R3: When a context with the last flag set completes, `dev_tc` is high for one cycle, in the same cycle as that context's done interrupt. When the flag is clear, there is no pulse.
- R4: After reset the engine uses context A. Only a context whose valid bit is set is run (control bit 4 for A, bit 3 for B). Completion clears that bit and hands over to the other context, which runs at once if it is valid.
- R5: `irq_ctx_a` or `irq_ctx_b` pulses for one cycle when the matching context completes. At most one interrupt line is high in any cycle.
- R6: A buffer that would cross a 4096-byte boundary is rejected, and so is a device-to-memory buffer whose base has a nonzero low six bits. On rejection, `irq_mem_err` pulses, control bit 1 (enable) and that context's valid bit clear, and no memory or device transfer takes place.
- R7: Clearing enable stops the engine only between bytes. A memory request already raised stays up with a stable address until it is granted, and an offered output byte stays until it is accepted. Setting enable again resumes from the same byte.
- R8: The diagnostic register shows, in bit 0, the context in use (1 means B). Bit 1 shows that the engine is enabled and mid-buffer. Bits 13:2 hold the bytes still to move.
- R9: A write to the context register in use is ignored while a buffer is in progress. A write to the other context register takes effect at once. Both read back at their addresses.
- R10: While control bit 2 is 1, both valid bits, the byte counter and the active state clear, and the engine returns to context A.
- R11: After `rst_n` the control and diagnostic registers read zero and all request, valid, pulse and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with grant |
| mem_gnt | input | 1 | Memory grant, completes the access |
| dev_out_valid | output | 1 | Byte offered to the device |
| dev_out_data | output | 8 | Byte to the device |
| dev_out_ready | input | 1 | Device accepts the byte |
| dev_in_valid | input | 1 | Device offers a byte |
| dev_in_data | input | 8 | Byte from the device |
| dev_in_ready | output | 1 | Engine accepts the device byte |
| dev_tc | output | 1 | Terminal-count pulse to the device |
| irq_ctx_a | output | 1 | Context A done pulse |
| irq_ctx_b | output | 1 | Context B done pulse |
| irq_mem_err | output | 1 | Rejected buffer pulse |

## Verification
On every cycle, the assertions check that a pending memory request or an offered output byte is never withdrawn or changed. This covers the case of a freeze arriving mid-byte. They also check that the three interrupt lines never fire together, that the terminal count only accompanies a completion, and that a rejection coincides with a quiet memory and device port. The effects that need scenarios are left to the bench. These are the byte order and content in both directions, the alternation between contexts, the counter shown while frozen, the ignored write to the busy context and the clearing done by a channel reset. The bench shows them at the ports and through register reads.

// File: rtl/pingpong_dma_pkg.sv
package pingpong_dma_pkg;
    localparam int CTX_W    = 64;
    localparam int LEN_LSB  = 32;
    localparam int LAST_BIT = 63;

    localparam logic [1:0] RA_CTX_A = 2'd0;
    localparam logic [1:0] RA_CTX_B = 2'd1;
    localparam logic [1:0] RA_CTRL  = 2'd2;
    localparam logic [1:0] RA_DIAG  = 2'd3;

    localparam int CB_DIR = 0;
    localparam int CB_EN  = 1;
    localparam int CB_RST = 2;
    localparam int CB_VB  = 3;
    localparam int CB_VA  = 4;

    // ST_GAP: between bytes (freeze point); ST_FIRST/ST_SECOND: the two halves of a byte
    typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_FIRST, ST_SECOND} phase_t;
endpackage

// File: rtl/pingpong_dma_ctxchk.sv
module pingpong_dma_ctxchk #(
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 4096,
    parameter int IN_ALIGN   = 64
) (
    input  logic [$clog2(PAGE_BYTES)-1:0] base_lo_i,
    input  logic [LEN_W-1:0]              len_i,
    input  logic                          to_mem_i,
    output logic                          bad_o,
    output logic                          empty_o
);
    localparam int PAGE_W  = $clog2(PAGE_BYTES);
    localparam int ALIGN_W = $clog2(IN_ALIGN);
    localparam int SUM_W   = ((PAGE_W > LEN_W) ? PAGE_W : LEN_W) + 1;

    logic [SUM_W-1:0] span;
    logic             crosses;
    logic             misaligned;

    always_comb begin
        span       = SUM_W'(base_lo_i) + SUM_W'(len_i);
        crosses    = span > SUM_W'(PAGE_BYTES);
        misaligned = to_mem_i && (base_lo_i[ALIGN_W-1:0] != '0);
        bad_o      = crosses || misaligned;
        empty_o    = (len_i == '0);
    end
endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma
    import pingpong_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 4096,
    parameter int IN_ALIGN   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_gnt,
    output logic              dev_out_valid,
    output logic [7:0]        dev_out_data,
    input  logic              dev_out_ready,
    input  logic              dev_in_valid,
    input  logic [7:0]        dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_tc,
    output logic              irq_ctx_a,
    output logic              irq_ctx_b,
    output logic              irq_mem_err
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int N_CTX  = 2;

    typedef struct packed {
        logic [CTX_W-1:0]  ctx_a;
        logic [CTX_W-1:0]  ctx_b;
        logic              dir;
        logic              en;
        logic              crst;
        logic              va;
        logic              vb;
        phase_t            ph;
        logic              cur;
        logic              run_dir;
        logic              run_last;
        logic [LEN_W-1:0]  left;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              p_a;
        logic              p_b;
        logic              p_err;
        logic              p_tc;
    } state_t;

    state_t q, d;

    logic [N_CTX-1:0][CTX_W-1:0] ctx_v;
    logic [N_CTX-1:0]            bad_v;
    logic [N_CTX-1:0]            empty_v;
    logic                        chan_rst_w;

    assign ctx_v      = {q.ctx_b, q.ctx_a};
    assign chan_rst_w = q.crst;

    for (genvar g = 0; g < N_CTX; g++) begin : g_chk
        pingpong_dma_ctxchk #(
            .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .IN_ALIGN(IN_ALIGN)
        ) u_ctxchk (
            .base_lo_i(ctx_v[g][PAGE_W-1:0]),
            .len_i    (ctx_v[g][LEN_LSB +: LEN_W]),
            .to_mem_i (q.dir),
            .bad_o    (bad_v[g]),
            .empty_o  (empty_v[g])
        );
    end

    logic             busy, cur_valid, other_valid, fin, fin_last, step;
    logic [CTX_W-1:0] cur_ctx;

    always_comb begin
        d         = q;
        d.p_a     = 1'b0;
        d.p_b     = 1'b0;
        d.p_err   = 1'b0;
        d.p_tc    = 1'b0;
        busy      = (q.ph != ST_IDLE);
        cur_ctx   = ctx_v[q.cur];
        cur_valid   = q.cur ? q.vb : q.va;
        other_valid = q.cur ? q.va : q.vb;
        fin       = 1'b0;
        fin_last  = 1'b0;
        step      = 1'b0;

        // software side
        if (reg_we) begin
            unique case (reg_addr)
                RA_CTX_A: if (!(busy && !q.cur)) d.ctx_a = reg_wdata;
                RA_CTX_B: if (!(busy && q.cur))  d.ctx_b = reg_wdata;
                RA_CTRL: begin
                    d.dir  = reg_wdata[CB_DIR];
                    d.en   = reg_wdata[CB_EN];
                    d.crst = reg_wdata[CB_RST];
                    d.vb   = reg_wdata[CB_VB];
                    d.va   = reg_wdata[CB_VA];
                end
                default: ;
            endcase
        end

        // engine side
        unique case (q.ph)
            ST_IDLE: begin
                if (q.en && !q.crst) begin
                    if (cur_valid) begin
                        if (bad_v[q.cur]) begin
                            d.p_err = 1'b1;
                            d.en    = 1'b0;
                            if (q.cur) d.vb = 1'b0;
                            else       d.va = 1'b0;
                        end else if (empty_v[q.cur]) begin
                            fin      = 1'b1;
                            fin_last = cur_ctx[LAST_BIT];
                        end else begin
                            d.ph       = ST_GAP;
                            d.left     = cur_ctx[LEN_LSB +: LEN_W];
                            d.addr     = cur_ctx[ADDR_W-1:0];
                            d.run_dir  = q.dir;
                            d.run_last = cur_ctx[LAST_BIT];
                        end
                    end else if (other_valid) begin
                        d.cur = ~q.cur;
                    end
                end
            end
            ST_GAP: if (q.en) d.ph = ST_FIRST;
            ST_FIRST: begin
                if (!q.run_dir && mem_gnt) begin
                    d.data = mem_rdata;
                    d.ph   = ST_SECOND;
                end else if (q.run_dir && dev_in_valid) begin
                    d.data = dev_in_data;
                    d.ph   = ST_SECOND;
                end
            end
            ST_SECOND: begin
                step = q.run_dir ? mem_gnt : dev_out_ready;
                if (step) begin
                    d.left = q.left - 1'b1;
                    d.addr = q.addr + 1'b1;
                    if (q.left == LEN_W'(1)) begin
                        fin      = 1'b1;
                        fin_last = q.run_last;
                    end else begin
                        d.ph = ST_GAP;
                    end
                end
            end
        endcase

        if (fin) begin
            d.ph   = ST_IDLE;
            d.p_a  = !q.cur;
            d.p_b  = q.cur;
            d.p_tc = fin_last;
            if (q.cur) d.vb = 1'b0;
            else       d.va = 1'b0;
            d.cur  = ~q.cur;
        end

        if (q.crst) begin
            d.va    = 1'b0;
            d.vb    = 1'b0;
            d.left  = '0;
            d.ph    = ST_IDLE;
            d.cur   = 1'b0;
            d.p_a   = 1'b0;
            d.p_b   = 1'b0;
            d.p_err = 1'b0;
            d.p_tc  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (reg_addr)
            RA_CTX_A: reg_rdata = q.ctx_a;
            RA_CTX_B: reg_rdata = q.ctx_b;
            RA_CTRL:  reg_rdata = 64'({q.va, q.vb, q.crst, q.en, q.dir});
            default:  reg_rdata = 64'({q.left, q.en && busy, q.cur});
        endcase
    end

    assign mem_req       = ((q.ph == ST_FIRST) && !q.run_dir) || ((q.ph == ST_SECOND) && q.run_dir);
    assign mem_we        = (q.ph == ST_SECOND) && q.run_dir;
    assign mem_addr      = q.addr;
    assign mem_wdata     = q.data;
    assign dev_out_valid = (q.ph == ST_SECOND) && !q.run_dir;
    assign dev_out_data  = q.data;
    assign dev_in_ready  = (q.ph == ST_FIRST) && q.run_dir;
    assign dev_tc        = q.p_tc;
    assign irq_ctx_a     = q.p_a;
    assign irq_ctx_b     = q.p_b;
    assign irq_mem_err   = q.p_err;
endmodule

// File: rtl/pingpong_dma_chk.sv
module pingpong_dma_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chan_rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              dev_out_valid,
    input logic              dev_out_ready,
    input logic [7:0]        dev_out_data,
    input logic              dev_in_ready,
    input logic              dev_tc,
    input logic              irq_a,
    input logic              irq_b,
    input logic              irq_err
);
    // R7: a raised memory request is held, unchanged, until granted
    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n || chan_rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7: an offered output byte is held until accepted
    assert_out_held_R7: assert property (@(posedge clk) disable iff (!rst_n || chan_rst)
        (dev_out_valid && !dev_out_ready) |=> (dev_out_valid && $stable(dev_out_data)));

    // R3: terminal count only together with a completion
    assert_tc_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dev_tc |-> (irq_a || irq_b));

    // R5: no two interrupt lines at once
    assert_irq_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_a, irq_b, irq_err}));

    // R6: a rejection happens with both ports quiet
    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (!mem_req && !dev_out_valid && !dev_in_ready));
endmodule

bind pingpong_dma pingpong_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chan_rst     (chan_rst_w),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_gnt      (mem_gnt),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready),
    .dev_out_data (dev_out_data),
    .dev_in_ready (dev_in_ready),
    .dev_tc       (dev_tc),
    .irq_a        (irq_ctx_a),
    .irq_b        (irq_ctx_b),
    .irq_err      (irq_mem_err)
);

// File: tb/pingpong_dma_tb.sv
`timescale 1ns/1ps
module pingpong_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd3;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        dev_out_valid, dev_out_ready, dev_in_valid, dev_in_ready;
    logic [7:0]  dev_out_data, dev_in_data;
    logic        dev_tc, irq_ctx_a, irq_ctx_b, irq_mem_err;

    always #2.5 clk = ~clk;

    pingpong_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_ready(dev_out_ready), .dev_in_valid(dev_in_valid),
        .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_tc(dev_tc), .irq_ctx_a(irq_ctx_a), .irq_ctx_b(irq_ctx_b),
        .irq_mem_err(irq_mem_err)
    );

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [63:0] mkctx(input logic [15:0] base, input logic [11:0] len, input logic last);
        return {last, 19'd0, len, 16'd0, base};
    endfunction

    function automatic logic [63:0] cv(input logic va, input logic vb, input logic rst, input logic en, input logic dir);
        return 64'({va, vb, rst, en, dir});
    endfunction

    // device and memory models
    logic [2:0] st = '0;
    int in_idx = 0, out_cnt = 0, wr_cnt = 0, rd_cnt = 0;
    int tc_cnt = 0, a_cnt = 0, b_cnt = 0, e_cnt = 0;
    logic [7:0] obuf [0:1023];
    logic [7:0] wmem [0:8191];

    initial forever begin
        @(negedge clk);
        st = st + 3'd1;
    end

    assign mem_gnt       = mem_req && (st[1:0] != 2'd3);
    assign mem_rdata     = pat(mem_addr);
    assign dev_out_ready = (st[1:0] != 2'd1);
    assign dev_in_valid  = (st[1:0] != 2'd2);
    assign dev_in_data   = 8'((in_idx * 7) + 3);

    always @(posedge clk) begin
        if (mem_req && mem_gnt && mem_we) begin
            wmem[mem_addr[12:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_req && mem_gnt && !mem_we) rd_cnt <= rd_cnt + 1;
        if (dev_out_valid && dev_out_ready) begin
            obuf[out_cnt % 1024] <= dev_out_data;
            out_cnt <= out_cnt + 1;
        end
        if (dev_in_valid && dev_in_ready) in_idx <= in_idx + 1;
        if (dev_tc) tc_cnt <= tc_cnt + 1;
        if (irq_ctx_a) a_cnt <= a_cnt + 1;
        if (irq_ctx_b) b_cnt <= b_cnt + 1;
        if (irq_mem_err) e_cnt <= e_cnt + 1;
    end

    int errors = 0, checks = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(input int a0, input int b0, input int e0, input int need);
        for (int k = 0; k < 5000 && ((a_cnt - a0) + (b_cnt - b0) + (e_cnt - e0)) < need; k++)
            @(negedge clk);
    endtask

    // {dir, last, base[15:0], len[11:0]}
    localparam logic [29:0] VEC [5] = '{
        {1'b0, 1'b1, 16'h0103, 12'd5},
        {1'b0, 1'b0, 16'h0FFC, 12'd4},
        {1'b1, 1'b1, 16'h0240, 12'd7},
        {1'b1, 1'b0, 16'h0380, 12'd1},
        {1'b0, 1'b0, 16'h0500, 12'd0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        logic [63:0] v;
        int o0, i0, w0, r0, t0, a0, b0, e0, n, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        rd(2'd2, v); chk("R11 ctrl after reset", v, 64'd0);
        rd(2'd3, v); chk("R11 diag after reset", v, 64'd0);
        chk("R11 outputs low", {mem_req, dev_out_valid, dev_in_ready, dev_tc, irq_ctx_a, irq_ctx_b, irq_mem_err}, 0);

        // table of buffers, alternating A and B
        foreach (VEC[i]) begin
            logic dir, last;
            logic [15:0] base;
            logic [11:0] len;
            {dir, last, base, len} = VEC[i];
            o0 = out_cnt; i0 = in_idx; w0 = wr_cnt; t0 = tc_cnt; a0 = a_cnt; b0 = b_cnt; e0 = e_cnt;
            wr(2'(i % 2), mkctx(base, len, last));
            wr(2'd2, cv(i % 2 == 0, i % 2 == 1, 1'b0, 1'b1, dir));
            wait_done(a0, b0, e0, 1);
            repeat (2) @(negedge clk);
            chk("R4/R5 done line", {32'(a_cnt - a0), 32'(b_cnt - b0)}, (i % 2 == 0) ? {32'd1, 32'd0} : {32'd0, 32'd1});
            bad = 0;
            if (!dir) begin
                chk("R2 bytes to device", 64'(out_cnt - o0), 64'(len));
                for (int j = 0; j < int'(len); j++)
                    if (obuf[(o0 + j) % 1024] !== pat(32'(base) + 32'(j))) bad++;
            end else begin
                chk("R2 bytes to memory", 64'(wr_cnt - w0), 64'(len));
                for (int j = 0; j < int'(len); j++)
                    if (wmem[13'(base + 16'(j))] !== 8'(((i0 + j) * 7) + 3)) bad++;
            end
            chk("R1 byte content and order", 64'(bad), 64'd0);
            chk("R3 terminal count", 64'(tc_cnt - t0), 64'(last));
            rd(2'd3, v);
            chk("R4/R8 diag after completion", v, 64'((i % 2 == 0) ? 1 : 0));
        end

        // R6: misaligned device-to-memory buffer
        wr(2'd2, cv(0, 0, 1, 0, 0)); wr(2'd2, 64'd0);
        w0 = wr_cnt; i0 = in_idx; a0 = a_cnt; b0 = b_cnt; e0 = e_cnt;
        wr(2'd0, mkctx(16'h0241, 12'd4, 1'b0));
        wr(2'd2, cv(1, 0, 0, 1, 1));
        wait_done(a0, b0, e0, 1);
        repeat (2) @(negedge clk);
        chk("R6 error pulse misaligned", 64'(e_cnt - e0), 64'd1);
        chk("R6 no traffic misaligned", 64'((wr_cnt - w0) + (in_idx - i0)), 64'd0);
        rd(2'd2, v); chk("R6 enable and valid cleared", v, 64'd1);

        // R6: page crossing
        o0 = out_cnt; r0 = rd_cnt; e0 = e_cnt;
        wr(2'd0, mkctx(16'h0FFD, 12'd4, 1'b0));
        wr(2'd2, cv(1, 0, 0, 1, 0));
        wait_done(a0, b0, e0, 1);
        repeat (2) @(negedge clk);
        chk("R6 error pulse crossing", 64'(e_cnt - e0), 64'd1);
        chk("R6 no traffic crossing", 64'((out_cnt - o0) + (rd_cnt - r0)), 64'd0);

        // R7/R8/R9: freeze, busy-context write, ping-pong into B
        wr(2'd2, cv(0, 0, 1, 0, 0)); wr(2'd2, 64'd0);
        o0 = out_cnt; t0 = tc_cnt; a0 = a_cnt; b0 = b_cnt; e0 = e_cnt;
        wr(2'd0, mkctx(16'h0600, 12'd40, 1'b0));
        wr(2'd1, mkctx(16'h0700, 12'd3, 1'b1));
        wr(2'd2, cv(1, 1, 0, 1, 0));
        for (int k = 0; k < 2000 && (out_cnt - o0) < 5; k++) @(negedge clk);
        wr(2'd2, cv(1, 1, 0, 0, 0));
        repeat (30) @(negedge clk);
        n = out_cnt - o0;
        repeat (30) @(negedge clk);
        chk("R7 frozen no progress", 64'(out_cnt - o0), 64'(n));
        rd(2'd3, v); chk("R8 diag while frozen", v, 64'((40 - n) << 2));
        wr(2'd0, mkctx(16'h0900, 12'd2, 1'b1));
        rd(2'd0, v); chk("R9 busy context write ignored", v, mkctx(16'h0600, 12'd40, 1'b0));
        wr(2'd1, mkctx(16'h0780, 12'd3, 1'b1));
        rd(2'd1, v); chk("R9 idle context write taken", v, mkctx(16'h0780, 12'd3, 1'b1));
        wr(2'd2, cv(1, 1, 0, 1, 0));
        wait_done(a0, b0, e0, 2);
        repeat (2) @(negedge clk);
        chk("R7 resumed total bytes", 64'(out_cnt - o0), 64'd43);
        bad = 0;
        for (int j = 0; j < 40; j++) if (obuf[(o0 + j) % 1024] !== pat(32'h600 + 32'(j))) bad++;
        for (int j = 0; j < 3; j++) if (obuf[(o0 + 40 + j) % 1024] !== pat(32'h780 + 32'(j))) bad++;
        chk("R9/R1 data after freeze and rewrite", 64'(bad), 64'd0);
        chk("R4 both contexts done in turn", {32'(a_cnt - a0), 32'(b_cnt - b0)}, {32'd1, 32'd1});
        chk("R3 terminal count from B only", 64'(tc_cnt - t0), 64'd1);
        rd(2'd2, v); chk("R4 valid bits cleared", v, 64'd2);

        // R10: channel reset mid-buffer
        o0 = out_cnt;
        wr(2'd0, mkctx(16'h0800, 12'd30, 1'b0));
        wr(2'd2, cv(1, 0, 0, 1, 0));
        for (int k = 0; k < 2000 && (out_cnt - o0) < 3; k++) @(negedge clk);
        wr(2'd2, cv(1, 1, 1, 1, 0));
        repeat (3) @(negedge clk);
        rd(2'd3, v); chk("R10 diag cleared", v, 64'd0);
        rd(2'd2, v); chk("R10 valid bits cleared", v, 64'd6);
        wr(2'd2, 64'd0);
        n = out_cnt;
        repeat (20) @(negedge clk);
        chk("R10 no traffic after reset", 64'(out_cnt - n), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule